// File: doc/BRIEF.md
# CPU-to-Memory Bus Handshake Controller

This controller joins a processor's simple memory port to a word-organised memory that sits behind an arbitrated bus. The processor holds a byte address and one read or write request level. The controller answers with a wait signal that stalls the processor until the transfer is finished. On the memory side the controller asks for the bus with an active-low request and waits for an active-low grant. It then performs one strobed transfer on a word address, which is the byte address with its two low bits dropped.

A write completes in the cycle after its strobe. A read completes when the memory pulses its data-valid input. The returned word then goes to the processor's read-data output in the same cycle that wait falls. The processor samples that word at the first clock edge after wait goes low and drops its request at that edge. Only single-word transfers are supported, so the controller releases the bus request in the strobe cycle.

Top module: `mem_bus_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released until a request arrives, mem_req_no, mem_strobe_no and mem_wsel_no are 1, cpu_wait_o is 0 and cpu_rdata_o is 0.
- R2: A request (cpu_rd_i or cpu_wr_i at 1) sampled while idle makes cpu_wait_o 1 and mem_req_no 0 in the next cycle.
- R3: mem_strobe_no goes low only in the cycle after a clock edge at which mem_req_no was 0 and mem_gnt_ni was sampled 0. It never goes low before a grant.
- R4: In the strobe cycle mem_req_no is already back at 1, so the bus is released one cycle after the grant.
- R5: mem_strobe_no stays low for exactly one cycle, and each access has exactly one strobe.
- R6: During the strobe, mem_addr_o equals the byte address latched at acceptance, shifted right by two bits.
- R7: During the strobe, mem_wsel_no is 1 for a read. For a write it is 0, and mem_wdata_o equals the write data latched at acceptance.
- R8: For a read, the word on mem_rdata_i at the edge where mem_rvalid_i is 1 (in the strobe cycle or later) appears on cpu_rdata_o. In that same cycle cpu_wait_o goes to 0.
- R9: For a write, cpu_wait_o goes to 0 in the cycle right after the strobe cycle.
- R10: mem_rvalid_i pulses outside a pending read leave cpu_rdata_o unchanged. A grant while idle causes no request and no strobe. cpu_rdata_o changes only in a cycle where cpu_wait_o falls.
- R11: If cpu_rd_i and cpu_wr_i are both 1 at acceptance, the access is a read and memory is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 26 | CPU byte address |
| cpu_rd_i | input | 1 | CPU read request level |
| cpu_wr_i | input | 1 | CPU write request level |
| cpu_wdata_i | input | 32 | CPU write data |
| cpu_rdata_o | output | 32 | Read data to CPU |
| cpu_wait_o | output | 1 | Stall to CPU |
| mem_req_no | output | 1 | Bus request, active low |
| mem_gnt_ni | input | 1 | Bus grant, active low |
| mem_strobe_no | output | 1 | Transfer strobe, active low |
| mem_wsel_no | output | 1 | Write select, active low (1 = read) |
| mem_addr_o | output | 24 | Memory word address |
| mem_wdata_o | output | 32 | Write data to memory |
| mem_rdata_i | input | 32 | Read data from memory |
| mem_rvalid_i | input | 1 | Single-cycle read data valid |

## Verification
The assertions check on every cycle the rules of the bus sequence. These are the one-cycle strobe, the strobe only after a sampled grant, the bus released by the strobe cycle, and wait rising the cycle after an idle request. They also check that read data changes only when wait falls and that no bus signal is active while the processor is not stalled. Address translation, the write-select and write-data values, and read data matching what memory holds all depend on stimulus. The bench's scenarios show these, using random grant and read latencies. The same holds for the ignored stray grant and data-valid pulses and for the precedence of read when both requests are raised.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_XFER  = 3'd2,
    ST_RWAIT = 3'd3,
    ST_DONE  = 3'd4
  } mbc_state_e;
endpackage

// File: rtl/mbc_fsm.sv
module mbc_fsm
  import mbc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_rd_i,
  input  logic cpu_wr_i,
  input  logic mem_gnt_ni,
  input  logic mem_rvalid_i,
  output logic accept_o,
  output logic op_wr_o,
  output logic capture_o,
  output logic cpu_wait_o,
  output logic mem_req_no,
  output logic mem_strobe_no,
  output logic mem_wsel_no
);
  mbc_state_e state_q, state_d;
  logic       op_wr_q;

  assign accept_o  = (state_q == ST_IDLE) && (cpu_rd_i || cpu_wr_i);
  assign capture_o = !op_wr_q && mem_rvalid_i &&
                     ((state_q == ST_XFER) || (state_q == ST_RWAIT));
  assign op_wr_o   = op_wr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = ST_REQ;
      ST_REQ:   if (!mem_gnt_ni) state_d = ST_XFER;
      ST_XFER:  state_d = (op_wr_q || capture_o) ? ST_DONE : ST_RWAIT;
      ST_RWAIT: if (capture_o) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      // read wins when both levels are raised
      if (accept_o) op_wr_q <= cpu_wr_i && !cpu_rd_i;
    end
  end

  assign mem_req_no    = (state_q != ST_REQ);
  assign mem_strobe_no = (state_q != ST_XFER);
  assign mem_wsel_no   = !((state_q == ST_XFER) && op_wr_q);
  assign cpu_wait_o    = (state_q == ST_REQ) || (state_q == ST_XFER) ||
                         (state_q == ST_RWAIT);

  a_r2_wait_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && (cpu_rd_i || cpu_wr_i)) |=> (cpu_wait_o && !mem_req_no));
  a_r3_strobe_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_strobe_no) |-> ($past(!mem_gnt_ni) && $past(!mem_req_no)));
  a_r4_req_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_strobe_no |-> mem_req_no);
  a_r5_strobe_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_strobe_no |=> mem_strobe_no);
endmodule

// File: rtl/mbc_datapath.sv
module mbc_datapath #(
  parameter int unsigned CPU_ADDR_W = 26,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned OFF_W      = 2,
  localparam int unsigned MEM_ADDR_W = CPU_ADDR_W - OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  accept_i,
  input  logic                  capture_i,
  input  logic [CPU_ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0]     cpu_wdata_i,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  output logic [DATA_W-1:0]     cpu_rdata_o,
  output logic [MEM_ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]     mem_wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      cpu_rdata_o <= '0;
    end else begin
      if (accept_i) begin
        mem_addr_o  <= cpu_addr_i[CPU_ADDR_W-1:OFF_W];
        mem_wdata_o <= cpu_wdata_i;
      end
      if (capture_i) cpu_rdata_o <= mem_rdata_i;
    end
  end
endmodule

// File: rtl/mem_bus_ctrl.sv
module mem_bus_ctrl #(
  parameter int unsigned CPU_ADDR_W = 26,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned OFF_W      = 2,
  localparam int unsigned MEM_ADDR_W = CPU_ADDR_W - OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CPU_ADDR_W-1:0] cpu_addr_i,
  input  logic                  cpu_rd_i,
  input  logic                  cpu_wr_i,
  input  logic [DATA_W-1:0]     cpu_wdata_i,
  output logic [DATA_W-1:0]     cpu_rdata_o,
  output logic                  cpu_wait_o,
  output logic                  mem_req_no,
  input  logic                  mem_gnt_ni,
  output logic                  mem_strobe_no,
  output logic                  mem_wsel_no,
  output logic [MEM_ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  input  logic                  mem_rvalid_i
);
  logic accept, capture, op_wr;

  mbc_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_rd_i     (cpu_rd_i),
    .cpu_wr_i     (cpu_wr_i),
    .mem_gnt_ni   (mem_gnt_ni),
    .mem_rvalid_i (mem_rvalid_i),
    .accept_o     (accept),
    .op_wr_o      (op_wr),
    .capture_o    (capture),
    .cpu_wait_o   (cpu_wait_o),
    .mem_req_no   (mem_req_no),
    .mem_strobe_no(mem_strobe_no),
    .mem_wsel_no  (mem_wsel_no)
  );

  mbc_datapath #(
    .CPU_ADDR_W(CPU_ADDR_W),
    .DATA_W    (DATA_W),
    .OFF_W     (OFF_W)
  ) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .cpu_addr_i (cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i),
    .mem_rdata_i(mem_rdata_i),
    .cpu_rdata_o(cpu_rdata_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  a_r10_rdata_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cpu_rdata_o) |-> $fell(cpu_wait_o));
  a_r9_bus_idle_without_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_wait_o |-> (mem_req_no && mem_strobe_no && mem_wsel_no));
  a_r7_read_wsel_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_strobe_no && !op_wr) |-> mem_wsel_no);
endmodule

// File: tb/mem_bus_ctrl_tb_top.sv
module mem_bus_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned AW = 26;
  localparam int unsigned DW = 32;
  localparam int unsigned MW = AW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_wait, req_n, strobe_n, wsel_n;
  logic          gnt_n = 1'b1;
  logic [MW-1:0] maddr;
  logic [DW-1:0] mwdata;
  logic [DW-1:0] mrdata = '0;
  logic          mrvalid = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  bit force_gnt = 0, spur = 0;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] ref_mem [16];
  logic [MW-1:0] exp_word;
  bit            exp_wr;
  logic [DW-1:0] exp_wd;
  int            strobe_cnt, strobe_cyc;
  logic          gnt_at_edge = 1'b1;
  int            gcnt = 0;
  bit            rd_pend = 0;
  int            rd_lat = 0;
  logic [3:0]    rd_idx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_bus_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .cpu_rd_i(cpu_rd),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .cpu_wait_o(cpu_wait), .mem_req_no(req_n), .mem_gnt_ni(gnt_n),
    .mem_strobe_no(strobe_n), .mem_wsel_no(wsel_n), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .mem_rvalid_i(mrvalid)
  );

  function automatic logic [DW-1:0] init_word(int i);
    return 32'h9E37_79B9 * (i + 1) ^ 32'h0F0F_1234;
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    gnt_at_edge = gnt_n;
  end

  // arbiter model
  always @(negedge clk) begin
    if (force_gnt) gnt_n <= 1'b0;
    else if (!req_n) begin
      if (gcnt == 0) gnt_n <= 1'b0;
      else gcnt--;
    end else begin
      gnt_n <= 1'b1;
      gcnt = int'($urandom_range(0, 3));
    end
  end

  // memory model plus strobe monitor
  always @(negedge clk) begin
    mrvalid <= 1'b0;
    if (spur) begin
      mrvalid <= 1'b1;
      mrdata  <= 32'hDEAD_BEEF;
    end
    if (rd_pend) begin
      if (rd_lat == 0) begin
        mrvalid <= 1'b1;
        mrdata  <= mem[rd_idx];
        rd_pend = 0;
      end else rd_lat--;
    end
    if (rst_n && !strobe_n) begin
      strobe_cnt++;
      strobe_cyc = cyc;
      check(req_n == 1'b1, "R4 req released in strobe cycle", 32'(req_n), 32'd1);
      check(gnt_at_edge == 1'b0, "R3 grant sampled before strobe", 32'(gnt_at_edge), 32'd0);
      check(maddr == exp_word, "R6 word address", 32'(maddr), 32'(exp_word));
      check(wsel_n == !exp_wr, "R7 write select", 32'(wsel_n), 32'(!exp_wr));
      if (exp_wr) begin
        check(mwdata == exp_wd, "R7 write data", mwdata, exp_wd);
        mem[maddr[3:0]] = mwdata;
      end else begin
        rd_pend = 1;
        rd_lat  = int'($urandom_range(0, 2));
        rd_idx  = maddr[3:0];
        if (rd_lat == 0 && ($urandom_range(0, 1) == 1)) begin
          // data-valid in the strobe cycle itself is not modelled here
          rd_lat = 0;
        end
      end
    end
  end

  task automatic access(bit rd, bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    int guard = 0;
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
    exp_word = a[AW-1:2]; exp_wr = wr && !rd; exp_wd = d;
    strobe_cnt = 0;
    @(posedge clk); @(negedge clk);
    check(cpu_wait == 1'b1 && req_n == 1'b0, "R2 wait and request after accept",
          {30'd0, cpu_wait, req_n}, 32'd2);
    while (cpu_wait && guard < 50) begin
      @(posedge clk); @(negedge clk);
      guard++;
    end
    if (exp_wr) begin
      check(cyc == strobe_cyc + 1, "R9 write completes after strobe",
            32'(cyc), 32'(strobe_cyc + 1));
      ref_mem[a[5:2]] = d;
    end else begin
      check(cpu_rdata == ref_mem[a[5:2]], rd && wr ? "R11 both levels read" : "R8 read data",
            cpu_rdata, ref_mem[a[5:2]]);
    end
    check(strobe_cnt == 1, "R5 one strobe per access", 32'(strobe_cnt), 32'd1);
    @(posedge clk); @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) begin
      mem[i] = init_word(i);
      ref_mem[i] = init_word(i);
    end
    repeat (3) @(negedge clk);
    check(req_n && strobe_n && wsel_n && !cpu_wait && cpu_rdata == '0,
          "R1 reset state", {27'd0, req_n, strobe_n, wsel_n, cpu_wait, |cpu_rdata}, 32'h1C);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_n && strobe_n && wsel_n && !cpu_wait, "R1 idle after reset",
          {28'd0, req_n, strobe_n, wsel_n, cpu_wait}, 32'hE);

    // directed: unaligned byte address, write then read back
    access(1'b0, 1'b1, 26'h000_0007, 32'hA5A5_0001);
    access(1'b1, 1'b0, 26'h000_0004, 32'h0);
    access(1'b1, 1'b0, 26'h3FF_FFFF, 32'h0);

    // R11: both levels raised acts as read, memory untouched
    access(1'b1, 1'b1, 26'h000_0010, 32'hFFFF_0000);
    access(1'b1, 1'b0, 26'h000_0010, 32'h0);

    // R10: stray grant while idle
    @(negedge clk); force_gnt = 1;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check(req_n && strobe_n && !cpu_wait, "R10 idle grant ignored",
            {29'd0, req_n, strobe_n, cpu_wait}, 32'h6);
    end
    force_gnt = 0;

    // R10: stray data-valid while idle
    held = cpu_rdata;
    @(negedge clk); spur = 1;
    @(negedge clk); spur = 0;
    @(posedge clk); @(negedge clk);
    check(cpu_rdata == held, "R10 stray data-valid ignored", cpu_rdata, held);

    // random mix
    for (int n = 0; n < 60; n++) begin
      bit w = ($urandom_range(0, 1) == 1);
      access(!w, w, AW'($urandom()), $urandom());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule